// File: doc/BRIEF.md
# Addressed Serial Frame Receiver

This block receives asynchronous serial frames on a single line and hands each byte to a host. It can take 8-bit frames or 9-bit frames, where the ninth bit follows the eighth data bit. The line is sampled with a 16x oversampling tick supplied from outside, and every bit is taken by a majority vote around its middle. A stop bit sampled low raises a framing-error flag that stays set until the host clears it.

On a shared multi-drop link the ninth bit marks address frames. When filtering is on in 9-bit operation, a frame is accepted only if its ninth bit is high and its byte equals the local slave address at every position that the mask keeps. A mask bit at zero turns that position into a don't-care. Several receivers can therefore answer to one address frame, or a single receiver can be picked out. Once it has been selected, the host turns filtering off to take the data frames that follow.

One host-visible bit is shared. With the view select at 1 it reads and writes the framing-error flag. With the view select at 0 it reads and writes the frame-length mode.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, rx_done_o, frame_err_o, rx_bit9_o and rx_data_o are 0, and the frame-length mode is 0 (8-bit frames).
- R2: A frame starts only on a high-to-low transition of the line while rx_en_i is 1. A frame sent while rx_en_i is 0 leaves rx_done_o and rx_data_o unchanged.
- R3: If the line is back high at the middle of the start bit, reception is abandoned and no frame is reported.
- R4: Each bit is decided by a majority of three samples taken on consecutive ticks around the bit centre, so a glitch covering one sample does not change the bit.
- R5: Data bits arrive LSB first. In 8-bit mode a completed frame loads rx_data_o, copies the stop bit value into rx_bit9_o, and sets rx_done_o. rx_done_o then stays set until done_clr_i is pulsed.
- R6: In 9-bit mode (mode bit 1), the ninth received bit appears on rx_bit9_o and the first eight bits appear on rx_data_o.
- R7: A stop bit sampled low sets frame_err_o. The frame is still reported when it is otherwise accepted.
- R8: frame_err_o is sticky. Only a write of 0 to the shared bit while fe_view_i is 1 clears it. A write of 1 leaves it unchanged, and later good frames do not clear it.
- R9: With fe_view_i at 0, the shared bit reads and writes the frame-length mode (1 means 9-bit frames), and such writes do not touch frame_err_o. With fe_view_i at 1, reg_rd_o shows frame_err_o.
- R10: With mp_en_i at 1 in 9-bit mode, a frame sets rx_done_o only if its ninth bit is 1 and ((byte XOR slave_addr_i) AND addr_mask_i) is 0. A rejected frame leaves rx_done_o and rx_data_o unchanged.
- R11: With mp_en_i at 0, every completed frame sets rx_done_o, whatever its ninth bit or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en_i | input | 1 | Allows new frames to start |
| mp_en_i | input | 1 | Enables address filtering in 9-bit mode |
| fe_view_i | input | 1 | Shared-bit view: 1 shows the error flag, 0 shows the mode |
| reg_wr_i | input | 1 | Write strobe for the shared bit |
| reg_wd_i | input | 1 | Write value for the shared bit |
| reg_rd_o | output | 1 | Read value of the shared bit |
| done_clr_i | input | 1 | Clears the receive-done flag |
| slave_addr_i | input | 8 | Local slave address |
| addr_mask_i | input | 8 | Address mask; a 0 bit is don't-care |
| rx_data_o | output | 8 | Last accepted byte |
| rx_bit9_o | output | 1 | Ninth bit, or the stop bit in 8-bit mode |
| rx_done_o | output | 1 | Receive-done flag |
| frame_err_o | output | 1 | Sticky framing-error flag |

## Verification
The line passes through two synchronizer flops. The decision for the stop bit falls on the tick at the middle of the stop bit, and rx_done_o, rx_data_o, rx_bit9_o and frame_err_o change one clock after that tick. Register writes and done_clr_i take effect on the next clock edge. To stay clear of every one of these latencies, the bench drives two full bit times of idle line after each stop bit before it samples. It samples only on falling clock edges, and it checks each register effect one full clock after the strobe.

// File: rtl/uarx_pkg.sv
package uarx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/uarx_vote.sv
module uarx_vote
    import uarx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    input  logic sample_i,
    output logic rx_o,
    output logic maj_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [1:0]             smp;
    } vote_regs_t;

    vote_regs_t q, d;

    assign rx_o  = q.sync[SYNC_STAGES-1];
    assign maj_o = maj3(q.smp[1], q.smp[0], rx_o);

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], rx_i};
        if (sample_i) d.smp = {q.smp[0], rx_o};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end
endmodule

// File: rtl/uarx_match.sv
module uarx_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] addr_i,
    input  logic [W-1:0] slave_i,
    input  logic [W-1:0] mask_i,
    output logic         hit_o
);
    logic [W-1:0] ok_w;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign ok_w[g] = !mask_i[g] || (addr_i[g] == slave_i[g]);
    end

    assign hit_o = &ok_w;
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uarx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              os_tick_i,
    input  logic              rx_en_i,
    input  logic              mp_en_i,
    input  logic              fe_view_i,
    input  logic              reg_wr_i,
    input  logic              reg_wd_i,
    output logic              reg_rd_o,
    input  logic              done_clr_i,
    input  logic [DATA_W-1:0] slave_addr_i,
    input  logic [DATA_W-1:0] addr_mask_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_bit9_o,
    output logic              rx_done_o,
    output logic              frame_err_o
);
    localparam int CNT_W = $clog2(OS);
    localparam int MID   = OS / 2;
    localparam int SH_W  = DATA_W + 1;
    localparam int IDX_W = $clog2(SH_W + 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [SH_W-1:0]   sh;
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              done;
        logic              fe;
        logic              mode9;
        logic              rx_prev;
    } rx_regs_t;

    rx_regs_t q, d;

    logic              rx_s, maj, sample_en, hit;
    logic              tick_mid, tick_end, accept, frame_b9;
    logic [DATA_W-1:0] frame_byte;
    logic [IDX_W-1:0]  last_idx;

    assign tick_mid  = os_tick_i && (q.cnt == CNT_W'(MID));
    assign tick_end  = os_tick_i && (q.cnt == CNT_W'(OS - 1));
    assign sample_en = os_tick_i && (q.st != ST_IDLE) &&
                       ((q.cnt == CNT_W'(MID - 2)) || (q.cnt == CNT_W'(MID - 1)));

    uarx_vote #(.SYNC_STAGES(2)) i_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_i     (rx_i),
        .sample_i (sample_en),
        .rx_o     (rx_s),
        .maj_o    (maj)
    );

    assign frame_byte = q.mode9 ? q.sh[DATA_W-1:0] : q.sh[SH_W-1:1];
    assign frame_b9   = q.mode9 ? q.sh[SH_W-1] : maj;
    assign last_idx   = q.mode9 ? IDX_W'(SH_W - 1) : IDX_W'(DATA_W - 1);

    uarx_match #(.W(DATA_W)) i_match (
        .addr_i  (frame_byte),
        .slave_i (slave_addr_i),
        .mask_i  (addr_mask_i),
        .hit_o   (hit)
    );

    assign accept = !mp_en_i || !q.mode9 || (frame_b9 && hit);

    always_comb begin
        d         = q;
        d.rx_prev = rx_s;
        if (done_clr_i) d.done = 1'b0;
        if (reg_wr_i) begin
            if (fe_view_i) begin
                if (!reg_wd_i) d.fe = 1'b0;
            end else begin
                d.mode9 = reg_wd_i;
            end
        end
        if (os_tick_i && q.st != ST_IDLE) d.cnt = q.cnt + 1'b1;
        unique case (q.st)
            ST_IDLE: begin
                d.cnt = '0;
                if (rx_en_i && q.rx_prev && !rx_s) d.st = ST_START;
            end
            ST_START: begin
                if (tick_mid && maj) begin
                    d.st = ST_IDLE;
                end else if (tick_end) begin
                    d.st  = ST_DATA;
                    d.cnt = '0;
                    d.idx = '0;
                end
            end
            ST_DATA: begin
                if (tick_mid) d.sh = {maj, q.sh[SH_W-1:1]};
                if (tick_end) begin
                    d.cnt = '0;
                    if (q.idx == last_idx) d.st = ST_STOP;
                    else                   d.idx = q.idx + 1'b1;
                end
            end
            ST_STOP: begin
                if (tick_mid) begin
                    if (!maj) d.fe = 1'b1;
                    if (accept) begin
                        d.data = frame_byte;
                        d.bit9 = frame_b9;
                        d.done = 1'b1;
                    end
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.rx_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_data_o   = q.data;
    assign rx_bit9_o   = q.bit9;
    assign rx_done_o   = q.done;
    assign frame_err_o = q.fe;
    assign reg_rd_o    = fe_view_i ? q.fe : q.mode9;

    // R8
    fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.fe && !(reg_wr_i && fe_view_i && !reg_wd_i) |=> q.fe);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) && !rx_en_i |=> (q.st == ST_IDLE));

    // R5
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> ($past(q.st) == ST_STOP));

    // R10
    mp_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) && $past(mp_en_i) && $past(q.mode9) |->
            rx_bit9_o && (((rx_data_o ^ $past(slave_addr_i)) & $past(addr_mask_i)) == '0));

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.data) |-> ($past(q.st) == ST_STOP));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && !fe_view_i) |=> $stable(q.mode9));
endmodule

// File: tb/test_uart_addr_rx.sv
module test_uart_addr_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       rx_en = 1'b0, mp_en = 1'b0, fe_view = 1'b0;
    logic       reg_wr = 1'b0, reg_wd = 1'b0, done_clr = 1'b0;
    logic [7:0] sa = 8'h00, mask = 8'h00;
    logic       reg_rd, bit9, done, fe;
    logic [7:0] data;

    int n_chk = 0, n_fail = 0;
    int tick_div = 1;
    int tick_cnt = 0;

    always #5 clk = ~clk;

    uart_addr_rx i_uart_addr_rx (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .os_tick_i(tick),
        .rx_en_i(rx_en), .mp_en_i(mp_en), .fe_view_i(fe_view),
        .reg_wr_i(reg_wr), .reg_wd_i(reg_wd), .reg_rd_o(reg_rd),
        .done_clr_i(done_clr), .slave_addr_i(sa), .addr_mask_i(mask),
        .rx_data_o(data), .rx_bit9_o(bit9), .rx_done_o(done), .frame_err_o(fe)
    );

    always @(negedge clk) begin
        tick     <= (tick_cnt == 0);
        tick_cnt <= (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [8:0] val, input int nb, input logic stop, input int glitch_bit);
        int bc;
        bc = 16 * tick_div;
        @(negedge clk) rx = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx = val[i];
            if (i == glitch_bit) begin
                repeat (8) @(negedge clk);
                rx = ~val[i];
                @(negedge clk) rx = val[i];
                repeat (bc - 9) @(negedge clk);
            end else begin
                repeat (bc) @(negedge clk);
            end
        end
        rx = stop;
        repeat (bc) @(negedge clk);
        rx = 1'b1;
        repeat (2 * bc) @(negedge clk);
    endtask

    task automatic wr_shared(input logic view, input logic val);
        @(negedge clk) begin fe_view = view; reg_wr = 1'b1; reg_wd = val; end
        @(negedge clk) reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic clr_done();
        @(negedge clk) done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] bytes8 [4] = '{8'h55, 8'hA3, 8'h00, 8'hFF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 done", done, 0);
        check("R1 fe", fe, 0);
        check("R1 data", data, 0);
        check("R1 bit9", bit9, 0);
        check("R1 mode", reg_rd, 0);

        // R2 disabled receiver ignores a frame
        send(9'h03C, 8, 1'b1, -1);
        check("R2 done while disabled", done, 0);
        check("R2 data while disabled", data, 0);
        rx_en = 1'b1;

        // R5 8-bit frames, LSB first, stop bit into ninth bit
        foreach (bytes8[k]) begin
            send({1'b0, bytes8[k]}, 8, 1'b1, -1);
            check("R5 done", done, 1);
            check("R5 data", data, bytes8[k]);
            check("R5 bit9 = stop", bit9, 1);
            clr_done();
            check("R5 done cleared", done, 0);
        end

        // R3 false start
        @(negedge clk) rx = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (64) @(negedge clk);
        check("R3 no done on false start", done, 0);
        check("R3 data kept", data, 8'hFF);

        // R4 single-sample glitch outvoted (bit 2 of 0xA5 is 1)
        send(9'h0A5, 8, 1'b1, 2);
        check("R4 glitch data", data, 8'hA5);
        clr_done();

        // R4 slower tick
        tick_div = 3;
        send(9'h0C6, 8, 1'b1, -1);
        check("R4 slow tick data", data, 8'hC6);
        clr_done();
        tick_div = 1;

        // R7 framing error still reports
        send(9'h05A, 8, 1'b0, -1);
        check("R7 fe set", fe, 1);
        check("R7 done", done, 1);
        check("R7 data", data, 8'h5A);
        check("R7 bit9 = stop", bit9, 0);
        clr_done();

        // R8 sticky
        send(9'h011, 8, 1'b1, -1);
        check("R8 fe stays after good frame", fe, 1);
        clr_done();
        wr_shared(1'b1, 1'b1);
        check("R8 write 1 keeps fe", fe, 1);
        fe_view = 1'b1;
        @(negedge clk);
        check("R9 view shows fe", reg_rd, 1);
        wr_shared(1'b0, 1'b1);
        check("R9 mode written", reg_rd, 1);
        check("R9 fe untouched by mode write", fe, 1);
        wr_shared(1'b1, 1'b0);
        check("R8 write 0 clears fe", fe, 0);
        fe_view = 1'b0;
        @(negedge clk);
        check("R9 mode kept", reg_rd, 1);

        // R6 / R11 9-bit frames with filtering off
        send(9'h1E7, 9, 1'b1, -1);
        check("R6 data", data, 8'hE7);
        check("R6 bit9", bit9, 1);
        check("R11 done b9=1", done, 1);
        clr_done();
        send(9'h03B, 9, 1'b1, -1);
        check("R6 bit9 zero", bit9, 0);
        check("R11 done b9=0", done, 1);
        clr_done();

        // R10 full address sweep
        sa = 8'hF1; mask = 8'hFA; mp_en = 1'b1;
        for (int a = 0; a < 256; a++) begin
            logic       exp_hit;
            logic [7:0] prev;
            prev    = data;
            exp_hit = (((a[7:0] ^ sa) & mask) == 8'h00);
            send({1'b1, a[7:0]}, 9, 1'b1, -1);
            check("R10 sweep done", done, exp_hit);
            check("R10 sweep data", data, exp_hit ? a[7:0] : prev);
            if (exp_hit) clr_done();
        end
        // R10 matching byte with ninth bit 0 is ignored
        send(9'h0F1, 9, 1'b1, -1);
        check("R10 data frame ignored", done, 0);
        // R10 all-zero mask accepts any address
        mask = 8'h00;
        send(9'h13C, 9, 1'b1, -1);
        check("R10 mask zero done", done, 1);
        check("R10 mask zero data", data, 8'h3C);
        clr_done();
        // R11 filtering off takes a data frame
        mp_en = 1'b0;
        send(9'h077, 9, 1'b1, -1);
        check("R11 data frame taken", done, 1);
        check("R11 data", data, 8'h77);

        finish_run();
    end
endmodule